// File: doc/BRIEF.md
# Calibrated Inverse-Curve Corrector

This block straightens a static transfer-curve error in a stream of decimated converter words. It holds a small table of measured responses, one for each of sixteen calibration levels spaced evenly across the input range. The table is filled on chip. The host holds the converter input at a known DC level, raises the calibration mode, names the table slot and pulses a start strobe. The block then averages a fixed run of 512 valid words and writes the mean into that slot.

Once every slot holds a value and the stored values rise strictly from slot to slot, the block is calibrated. In run mode each full-precision word is placed within the measured curve. It is then mapped by linear interpolation onto the ideal evenly spaced output codes. The result is rounded to an 8-bit code only after that mapping. Until the table is valid, run-mode words pass through as their upper eight bits.

Top module: `inv_curve_corrector`

## Requirements
- R1: After reset all outputs are low or zero, including out_valid, out_code, cal_busy, cal_done, calibrated and cal_error, and every table slot is marked empty.
- R2: With cal_mode high and cal_busy low, a cal_start pulse latches cal_point, and cal_busy is high from the next cycle on.
- R3: While cal_busy is high, each cycle with in_valid high adds in_word to an accumulator. On the 512th such word the slot receives the sum shifted right by 9 (rounded down). At that same edge cal_busy falls and cal_done pulses for exactly one cycle.
- R4: calibrated goes high only when all 16 slots have been written and each slot holds a value strictly greater than the slot below it. The status follows a slot write by one cycle.
- R5: If all 16 slots are written but the values do not rise strictly, cal_error is high, calibrated is low, and run mode applies no correction (pass-through as in R6).
- R6: When calibrated is low, a run-mode word produces out_code equal to in_word bits [15:8].
- R7: When calibrated, a word w with t[k] <= w < t[k+1] (t being the slot values, k the highest such slot in 0..14) gives code = (272*k + floor(272*(w - t[k])/(t[k+1] - t[k])) + 8) >> 4. Slot i is thus ideal code 17*i, with the fraction carried to 4 extra bits and rounded half up.
- R8: When calibrated, a word w <= t[0] gives code 0, and a word w >= t[15] gives code 255.
- R9: out_valid equals in_valid AND NOT cal_mode delayed by exactly 3 cycles. No code is produced for words taken in calibration mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 16 | Decimated converter word, unsigned |
| cal_mode | input | 1 | 1 = calibration, 0 = run |
| cal_start | input | 1 | Starts averaging into the named slot |
| cal_point | input | 4 | Table slot to be filled |
| cal_busy | output | 1 | Averaging in progress |
| cal_done | output | 1 | One-cycle pulse when a slot is written |
| calibrated | output | 1 | Table complete and strictly rising |
| cal_error | output | 1 | Table complete but not strictly rising |
| out_valid | output | 1 | Corrected code qualifier |
| out_code | output | 8 | Corrected, quantised code |

## Verification
The hardest state to reach from the ports is a complete table that fails the rising-order check. No ordinary calibration sequence produces it. The bench first builds a good table and confirms correction. It then re-averages one middle slot at a level above its upper neighbour. It confirms that the error status appears, that words fall back to pass-through, and that restoring the slot restores correction. Interpolation is exercised at exact slot values, between slots and beyond both ends, as back-to-back streams that also test the fixed latency.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int ICC_IN_W     = 16;
  localparam int ICC_OUT_W    = 8;
  localparam int ICC_NPTS     = 16;
  localparam int ICC_AVG_LOG2 = 9;
  localparam int ICC_FRAC_W   = 4;

  // ideal code distance between neighbouring calibration slots
  function automatic int icc_step(input int out_w, input int npts);
    return ((1 << out_w) - 1) / (npts - 1);
  endfunction
endpackage

// File: rtl/icc_averager.sv
module icc_averager #(
  parameter int IN_W     = 16,
  parameter int NPTS     = 16,
  parameter int AVG_LOG2 = 9,
  localparam int PT_W    = $clog2(NPTS),
  localparam int ACC_W   = IN_W + AVG_LOG2,
  localparam int CNT_W   = AVG_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_mode,
  input  logic            cal_start,
  input  logic [PT_W-1:0] cal_point,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_word,
  output logic            busy,
  output logic            done,
  output logic            wr_en,
  output logic [PT_W-1:0] wr_idx,
  output logic [IN_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [PT_W-1:0]  idx_q, idx_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] sum_c;

  always_comb begin
    sum_c  = acc_q + ACC_W'(in_word);
    busy_d = busy_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    wr_en  = 1'b0;
    if (!busy_q) begin
      if (cal_mode && cal_start) begin
        busy_d = 1'b1;
        idx_d  = cal_point;
        acc_d  = '0;
        cnt_d  = '0;
      end
    end else if (in_valid) begin
      acc_d = sum_c;
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        wr_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wr_idx  = idx_q;
  assign wr_data = sum_c[ACC_W-1 -: IN_W];
endmodule

// File: rtl/icc_table.sv
module icc_table #(
  parameter int IN_W   = 16,
  parameter int NPTS   = 16,
  localparam int PT_W  = $clog2(NPTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PT_W-1:0]           wr_idx,
  input  logic [IN_W-1:0]           wr_data,
  output logic [NPTS-1:0][IN_W-1:0] tbl,
  output logic [NPTS-1:0]           stored,
  output logic                      cal_ok,
  output logic                      cal_err
);
  logic [NPTS-1:0][IN_W-1:0] tbl_q;
  logic [NPTS-1:0]           stored_q;
  logic [NPTS-1:0]           hit_c;
  logic                      rising_c;
  logic                      full_c;
  logic                      ok_q, err_q;

  always_comb begin
    for (int i = 0; i < NPTS; i++) begin
      hit_c[i] = wr_en && (wr_idx == PT_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q    <= '0;
      stored_q <= '0;
    end else begin
      for (int i = 0; i < NPTS; i++) begin
        if (hit_c[i]) begin
          tbl_q[i]    <= wr_data;
          stored_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rising_c = 1'b1;
    for (int i = 1; i < NPTS; i++) begin
      if (tbl_q[i] <= tbl_q[i-1]) rising_c = 1'b0;
    end
    full_c = &stored_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= full_c & rising_c;
      err_q <= full_c & ~rising_c;
    end
  end

  assign tbl     = tbl_q;
  assign stored  = stored_q;
  assign cal_ok  = ok_q;
  assign cal_err = err_q;
endmodule

// File: rtl/icc_pipe.sv
module icc_pipe #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 8,
  parameter int NPTS    = 16,
  parameter int FRAC_W  = 4,
  localparam int SEG_W  = $clog2(NPTS),
  localparam int STEP   = icc_pkg::icc_step(OUT_W, NPTS),
  localparam int MUL    = STEP << FRAC_W,
  localparam int MUL_W  = $clog2(MUL + 1),
  localparam int NUM_W  = IN_W + MUL_W,
  localparam int FULL_W = NUM_W + 2,
  localparam int MAXC   = (1 << OUT_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      run_en,
  input  logic [IN_W-1:0]           in_word,
  input  logic                      corr_en,
  input  logic [NPTS-1:0][IN_W-1:0] tbl,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_code
);
  // stage 1: segment search
  logic [SEG_W-1:0] seg_c;
  logic             lo_c, hi_c;
  logic             s1_v, s1_lo, s1_hi, s1_corr;
  logic [IN_W-1:0]  s1_w;
  logic [SEG_W-1:0] s1_seg;

  always_comb begin
    seg_c = '0;
    for (int i = 1; i < NPTS - 1; i++) begin
      seg_c = seg_c + SEG_W'(in_word >= tbl[i]);
    end
    lo_c = (in_word <= tbl[0]);
    hi_c = (in_word >= tbl[NPTS-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_w    <= '0;
      s1_seg  <= '0;
      s1_lo   <= 1'b0;
      s1_hi   <= 1'b0;
      s1_corr <= 1'b0;
    end else begin
      s1_v <= in_valid & run_en;
      if (in_valid & run_en) begin
        s1_w    <= in_word;
        s1_seg  <= seg_c;
        s1_lo   <= lo_c;
        s1_hi   <= hi_c;
        s1_corr <= corr_en;
      end
    end
  end

  // stage 2: segment operands
  logic [SEG_W-1:0] seg_nx_c;
  logic [IN_W-1:0]  diff_c, den_c;
  logic [OUT_W-1:0] base_c;
  logic             s2_v, s2_lo, s2_hi, s2_corr;
  logic [IN_W-1:0]  s2_diff, s2_den;
  logic [OUT_W-1:0] s2_base, s2_raw;

  always_comb begin
    seg_nx_c = s1_seg + SEG_W'(1);
    diff_c   = s1_w - tbl[s1_seg];
    den_c    = tbl[seg_nx_c] - tbl[s1_seg];
    base_c   = OUT_W'(s1_seg) * OUT_W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_diff <= '0;
      s2_den  <= '0;
      s2_base <= '0;
      s2_raw  <= '0;
      s2_lo   <= 1'b0;
      s2_hi   <= 1'b0;
      s2_corr <= 1'b0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_diff <= diff_c;
        s2_den  <= den_c;
        s2_base <= base_c;
        s2_raw  <= s1_w[IN_W-1 -: OUT_W];
        s2_lo   <= s1_lo;
        s2_hi   <= s1_hi;
        s2_corr <= s1_corr;
      end
    end
  end

  // stage 3: interpolate, round, quantise
  logic [NUM_W-1:0]  num_c, quo_c;
  logic [FULL_W-1:0] full_c, rnd_c;
  logic [OUT_W-1:0]  code_c;

  always_comb begin
    num_c  = NUM_W'(s2_diff) * NUM_W'(MUL);
    quo_c  = (s2_den != '0) ? (num_c / NUM_W'(s2_den)) : '0;
    full_c = (FULL_W'(s2_base) << FRAC_W) + FULL_W'(quo_c)
             + (FULL_W'(1) << (FRAC_W - 1));
    rnd_c  = full_c >> FRAC_W;
    if (!s2_corr)                      code_c = s2_raw;
    else if (s2_lo)                    code_c = '0;
    else if (s2_hi)                    code_c = OUT_W'(MAXC);
    else if (rnd_c > FULL_W'(MAXC))    code_c = OUT_W'(MAXC);
    else                               code_c = rnd_c[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) out_code <= code_c;
    end
  end
endmodule

// File: rtl/inv_curve_corrector.sv
module inv_curve_corrector #(
  parameter int IN_W     = icc_pkg::ICC_IN_W,
  parameter int OUT_W    = icc_pkg::ICC_OUT_W,
  parameter int NPTS     = icc_pkg::ICC_NPTS,
  parameter int AVG_LOG2 = icc_pkg::ICC_AVG_LOG2,
  parameter int FRAC_W   = icc_pkg::ICC_FRAC_W,
  localparam int PT_W    = $clog2(NPTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  input  logic             cal_mode,
  input  logic             cal_start,
  input  logic [PT_W-1:0]  cal_point,
  output logic             cal_busy,
  output logic             cal_done,
  output logic             calibrated,
  output logic             cal_error,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code
);
  // reset asserts at once, releases on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic                      wr_en;
  logic [PT_W-1:0]           wr_idx;
  logic [IN_W-1:0]           wr_data;
  logic [NPTS-1:0][IN_W-1:0] tbl;
  logic [NPTS-1:0]           stored_mask;

  icc_averager #(.IN_W(IN_W), .NPTS(NPTS), .AVG_LOG2(AVG_LOG2)) avg_i (
    .clk(clk), .rst_n(rst_n_s), .cal_mode(cal_mode), .cal_start(cal_start),
    .cal_point(cal_point), .in_valid(in_valid), .in_word(in_word),
    .busy(cal_busy), .done(cal_done), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data)
  );

  icc_table #(.IN_W(IN_W), .NPTS(NPTS)) tbl_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .tbl(tbl), .stored(stored_mask),
    .cal_ok(calibrated), .cal_err(cal_error)
  );

  icc_pipe #(.IN_W(IN_W), .OUT_W(OUT_W), .NPTS(NPTS), .FRAC_W(FRAC_W)) pipe_i (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .run_en(~cal_mode),
    .in_word(in_word), .corr_en(calibrated), .tbl(tbl),
    .out_valid(out_valid), .out_code(out_code)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int NPTS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            cal_mode,
  input logic            out_valid,
  input logic            cal_busy,
  input logic            cal_done,
  input logic            calibrated,
  input logic            cal_error,
  input logic [NPTS-1:0] stored
);
  logic [1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == 2'd3) |-> (out_valid == $past(in_valid & ~cal_mode, 3))); // R9
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(calibrated && cal_error)); // R5
  AST_STATUS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (calibrated || cal_error) |-> (&stored)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy))); // R3
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(cal_mode)); // R2
endmodule

bind inv_curve_corrector icc_checker #(.NPTS(NPTS)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .cal_mode(cal_mode),
  .out_valid(out_valid), .cal_busy(cal_busy), .cal_done(cal_done),
  .calibrated(calibrated), .cal_error(cal_error), .stored(stored_mask)
);

// File: tb/inv_curve_corrector_tb.sv
module inv_curve_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        cal_mode = 1'b0;
  logic        cal_start = 1'b0;
  logic [3:0]  cal_point = '0;
  logic        cal_busy, cal_done, calibrated, cal_error, out_valid;
  logic [7:0]  out_code;

  always #4 clk = ~clk;

  inv_curve_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .cal_mode(cal_mode), .cal_start(cal_start), .cal_point(cal_point),
    .cal_busy(cal_busy), .cal_done(cal_done), .calibrated(calibrated),
    .cal_error(cal_error), .out_valid(out_valid), .out_code(out_code)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    code;
    int    due;
    string tag;
  } exp_t;
  exp_t sb[$];

  int mt[16];
  bit mstored[16];
  bit mcal = 1'b0;
  bit merr = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_code(input int w);
    int k, d, q, c;
    if (!mcal) return w >> 8;
    if (w <= mt[0]) return 0;
    if (w >= mt[15]) return 255;
    k = 0;
    for (int i = 1; i < 15; i++) if (w >= mt[i]) k = i;
    d = mt[k+1] - mt[k];
    q = ((w - mt[k]) * 272) / d;
    c = (k * 272 + q + 8) >> 4;
    if (c > 255) c = 255;
    return c;
  endfunction

  function automatic void update_status();
    bit full, rising;
    full = 1'b1;
    rising = 1'b1;
    for (int i = 0; i < 16; i++) if (!mstored[i]) full = 1'b0;
    for (int i = 1; i < 16; i++) if (mt[i] <= mt[i-1]) rising = 1'b0;
    mcal = full & rising;
    merr = full & ~rising;
  endfunction

  // monitor: compares codes and arrival cycle
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_code == e.code[7:0], e.tag, out_code, e.code);
        check(cyc == e.due, "R9 latency", cyc, e.due);
      end
    end
  end

  task automatic run_words(input int w[$], input string tag);
    foreach (w[j]) begin
      exp_t e;
      cal_mode = 1'b0;
      in_valid = 1'b1;
      in_word  = w[j][15:0];
      e.code = expect_code(w[j]);
      e.due  = cyc + 3;
      e.tag  = tag;
      sb.push_back(e);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic calibrate(input int p, input int level);
    longint sum;
    sum = 0;
    cal_mode  = 1'b1;
    cal_start = 1'b1;
    cal_point = p[3:0];
    in_valid  = 1'b0;
    @(negedge clk);
    cal_start = 1'b0;
    check(cal_busy == 1'b1, "R2 busy after start", cal_busy, 1);
    for (int j = 0; j < 512; j++) begin
      int v;
      v = level + (j % 8) - 3 + ((j % 64 == 5) ? 2 : 0);
      sum += v;
      in_valid = 1'b1;
      in_word  = v[15:0];
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(cal_done == 1'b1 && cal_busy == 1'b0, "R3 done/busy at end",
          {cal_done, cal_busy}, 2);
    check(out_valid == 1'b0, "R9 no output in calibration", out_valid, 0);
    mt[p] = int'(sum >> 9);
    mstored[p] = 1'b1;
    update_status();
    @(negedge clk);
    check(cal_done == 1'b0, "R3 done single cycle", cal_done, 0);
    @(negedge clk);
    check(calibrated == mcal, "R4 calibrated status", calibrated, mcal);
    check(cal_error == merr, "R5 error status", cal_error, merr);
    cal_mode = 1'b0;
  endtask

  function automatic int level_of(input int i);
    return 4000 + 3000 * i + 50 * i * i;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      mt[i] = 0;
      mstored[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 0 && out_code == 0, "R1 outputs after reset", out_code, 0);
    check(cal_busy == 0 && cal_done == 0, "R1 busy/done after reset", cal_busy, 0);
    check(calibrated == 0 && cal_error == 0, "R1 status after reset", calibrated, 0);

    run_words('{16'h1234, 16'hFFFF, 16'h00FF, 16'h8001}, "R6 pass-through uncalibrated");

    for (int i = 0; i < 16; i++) begin
      calibrate(i, level_of(i));
      if (i == 7) run_words('{16'hABCD}, "R6 pass-through partial table");
    end
    check(calibrated == 1'b1, "R4 full rising table", calibrated, 1);

    run_words('{mt[3], mt[7], mt[14], mt[4] + (mt[5] - mt[4]) / 2, mt[9] + 1,
                mt[10] - 1}, "R7 interpolation");
    begin
      int ws[$];
      for (int j = 0; j < 15; j++) ws.push_back(5000 + j * 3777);
      run_words(ws, "R7 sweep");
    end
    run_words('{mt[0], mt[0] - 100, 0, mt[15], 65535, mt[15] - 1}, "R8 clamp ends");

    calibrate(5, level_of(6) + 500);
    check(cal_error == 1'b1 && calibrated == 1'b0, "R5 non-rising table",
          cal_error, 1);
    run_words('{16'h8000, 16'h2A55}, "R5 pass-through on error");

    calibrate(5, level_of(5));
    check(calibrated == 1'b1 && cal_error == 1'b0, "R4 table restored",
          calibrated, 1);
    run_words('{mt[5], mt[5] + 700, mt[2] + 10}, "R7 after restore");

    check(sb.size() == 0, "R9 all results delivered", sb.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule